// File: doc/BRIEF.md
# Three-Wire Serial Mode Controller

This block is a three-wire serial slave that runs in a system clock domain. An external controller frames a command with an active-low enable, clocks data on a serial clock, and presents one data bit per serial clock rising edge. The block samples all three serial lines through synchronizers and counts the serial clock edges. It holds the last twelve bits received. When the enable rises, it decodes the word, but only if the frame saw enough edges.

A decoded word can do two things, each selected by its own bit. It can load an 8-bit reference DAC code register, which raises a one-clock update strobe. It can also set a programmed output mode. The final grounded-output control merges that programmed mode with two hardware pins. The first pin picks whether the serial interface or the second pin owns the mode. The second pin, when it owns the mode, forces grounded mode combinationally with no clock involved.

The controller is a three-state machine. ST_IDLE moves to ST_SHIFT on the START transition, which is a falling enable. ST_SHIFT moves to ST_COMMIT on ACCEPT, a rising enable after at least three edges. It returns to ST_IDLE on ABORT, a rising enable after fewer than three edges. ST_COMMIT applies the word and returns to ST_IDLE on DONE.

Top module: `serial_mode_ctrl`

## Requirements
- R1: After reset the DAC code is 0, the strobe is low and the programmed mode is normal, so the grounded output is 0 while the select pin is high.
- R2: Bits enter MSB first, so the first bit of a 12-bit frame lands in bit 11. Bits 7..0 of the word form the DAC code.
- R3: A valid word with bit 10 = 0 leaves the DAC code unchanged and produces no strobe.
- R4: With the select pin high, a valid word sets grounded mode when bit 11 = 1 and normal mode when bit 11 = 0.
- R5: Nothing changes while the frame is open. Decoded results appear only after the enable rises.
- R6: A frame with fewer than three serial clock rising edges has no effect. A frame with exactly three edges is decoded.
- R7: A frame with more than 12 edges is decoded from the last 12 bits received.
- R8: A frame with 3 to 11 edges is decoded from a zero-filled register. The bits received occupy the low positions, and the last bit is bit 0.
- R9: With the select pin low, bit 11 is ignored. The override pin high gives normal mode. The override pin low forces grounded mode at once, with no clock edge needed.
- R10: With the select pin low, a valid word with bit 10 = 1 still loads the DAC code.
- R11: The update strobe is high for exactly one system clock after each valid DAC load, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en_n | input | 1 | Serial frame enable, active low |
| ser_clk | input | 1 | Serial clock, data taken on its rising edge |
| ser_dat | input | 1 | Serial data |
| mode_sel | input | 1 | High: serial interface owns the mode; low: override pin owns it |
| mode_ovr | input | 1 | Override pin; low forces grounded mode when mode_sel is low |
| dac_code | output | 8 | Registered reference DAC code |
| dac_upd | output | 1 | One-clock strobe after each DAC load |
| gnd_out | output | 1 | Final grounded-output control, 1 = grounded |

## Verification
The bench sends full 12-bit frames with and without the load bit. This separates DAC loading from mode setting, and a check taken before the enable rises shows that nothing is applied early. Frames of two, three, eleven and fourteen edges probe the validity threshold, the zero filling and the keep-the-last-twelve rule. A frame that sets grounded mode followed by a too-short frame shows that an invalid frame is fully dropped. With the select pin low, the bench toggles the override pin with no clock edge and sends words whose mode bit disagrees with the pin. This shows that the pin wins and that DAC loading still works. A strobe monitor counts pulses and flags any pulse longer than one clock.

// File: rtl/serial_mode_pkg.sv
package serial_mode_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } frame_state_t;

endpackage

// File: rtl/smc_sync.sv
module smc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    input  logic [WIDTH-1:0] rst_val,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= rst_val;
        end else begin
            pipe_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign sync_out = pipe_q[STAGES-1];

endmodule

// File: rtl/smc_frame_fsm.sv
module smc_frame_fsm
    import serial_mode_pkg::*;
#(
    parameter int WORD_W    = 12,
    parameter int DAC_W     = 8,
    parameter int LOAD_BIT  = 10,
    parameter int MODE_BIT  = 11,
    parameter int MIN_EDGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n_s,
    input  logic             sclk_s,
    input  logic             dat_s,
    output logic [DAC_W-1:0] dac_code,
    output logic             dac_upd,
    output logic             mode_gnd
);

    localparam int CNT_W   = $clog2(WORD_W + 1) + 1;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    frame_state_t      state_q, state_d;
    logic              en_prev_q, sclk_prev_q;
    logic              en_fall, en_rise, sclk_rise;
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  edge_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_prev_q   <= 1'b1;
            sclk_prev_q <= 1'b0;
        end else begin
            en_prev_q   <= en_n_s;
            sclk_prev_q <= sclk_s;
        end
    end

    assign en_fall   = en_prev_q & ~en_n_s;
    assign en_rise   = ~en_prev_q & en_n_s;
    assign sclk_rise = ~sclk_prev_q & sclk_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: START, ACCEPT, ABORT, DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (en_fall) state_d = ST_SHIFT;
            ST_SHIFT:  if (en_rise)
                           state_d = (edge_cnt_q >= CNT_W'(MIN_EDGES)) ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // shift register and edge counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            edge_cnt_q <= '0;
        end else if (state_q == ST_IDLE && en_fall) begin
            shreg_q    <= '0;
            edge_cnt_q <= '0;
        end else if (state_q == ST_SHIFT && sclk_rise && !en_n_s) begin
            shreg_q <= {shreg_q[WORD_W-2:0], dat_s};
            if (edge_cnt_q != CNT_W'(CNT_MAX)) edge_cnt_q <= edge_cnt_q + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_code <= '0;
            dac_upd  <= 1'b0;
            mode_gnd <= 1'b0;
        end else begin
            dac_upd <= 1'b0;
            if (state_q == ST_COMMIT) begin
                mode_gnd <= shreg_q[MODE_BIT];
                if (shreg_q[LOAD_BIT]) begin
                    dac_code <= shreg_q[DAC_W-1:0];
                    dac_upd  <= 1'b1;
                end
            end
        end
    end

    // R6
    min_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |-> (edge_cnt_q >= CNT_W'(MIN_EDGES)));

    // R11
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_upd |=> !dac_upd);

    // R3
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> dac_upd);

    // R5
    mode_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_gnd) |-> $past(state_q == ST_COMMIT));

    // R5
    commit_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |-> $past(state_q == ST_SHIFT));

endmodule

// File: rtl/smc_mode_mux.sv
module smc_mode_mux (
    input  logic mode_sel,
    input  logic mode_ovr,
    input  logic mode_gnd,
    output logic gnd_out
);

    always_comb begin
        if (mode_sel) gnd_out = mode_gnd;
        else          gnd_out = ~mode_ovr;
    end

endmodule

// File: rtl/serial_mode_ctrl.sv
module serial_mode_ctrl #(
    parameter int WORD_W      = 12,
    parameter int DAC_W       = 8,
    parameter int LOAD_BIT    = 10,
    parameter int MODE_BIT    = 11,
    parameter int MIN_EDGES   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_en_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             mode_sel,
    input  logic             mode_ovr,
    output logic [DAC_W-1:0] dac_code,
    output logic             dac_upd,
    output logic             gnd_out
);

    logic [2:0] sync_q;
    logic       mode_gnd;

    smc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_dat, ser_clk, ser_en_n}),
        .rst_val  (3'b001),
        .sync_out (sync_q)
    );

    smc_frame_fsm #(
        .WORD_W    (WORD_W),
        .DAC_W     (DAC_W),
        .LOAD_BIT  (LOAD_BIT),
        .MODE_BIT  (MODE_BIT),
        .MIN_EDGES (MIN_EDGES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_n_s   (sync_q[0]),
        .sclk_s   (sync_q[1]),
        .dat_s    (sync_q[2]),
        .dac_code (dac_code),
        .dac_upd  (dac_upd),
        .mode_gnd (mode_gnd)
    );

    smc_mode_mux u_mux (
        .mode_sel (mode_sel),
        .mode_ovr (mode_ovr),
        .mode_gnd (mode_gnd),
        .gnd_out  (gnd_out)
    );

endmodule

// File: tb/tb_serial_mode_ctrl.sv
module tb_serial_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_en_n = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       mode_sel = 1'b1;
    logic       mode_ovr = 1'b1;
    logic [7:0] dac_code;
    logic       dac_upd;
    logic       gnd_out;

    int checks = 0;
    int fails  = 0;
    int upd_cnt = 0;
    int wide_cnt = 0;
    logic upd_prev = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    serial_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .mode_sel(mode_sel), .mode_ovr(mode_ovr),
        .dac_code(dac_code), .dac_upd(dac_upd), .gnd_out(gnd_out)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (dac_upd) upd_cnt++;
            if (dac_upd && upd_prev) wide_cnt++;
            upd_prev <= dac_upd;
        end
    end

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [15:0] bits, input int n);
        ser_en_n = 1'b0;
        #100;
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            #100 ser_clk = 1'b1;
            #100 ser_clk = 1'b0;
        end
        #100;
    endtask

    task automatic close_frame();
        ser_en_n = 1'b1;
        #300;
    endtask

    task automatic test_reset();
        check(dac_code, 0, "R1 code");
        check(dac_upd, 0, "R1 strobe");
        check(gnd_out, 0, "R1 mode");
    endtask

    task automatic test_full_load();
        shift_bits(16'h04A5, 12);
        check(dac_code, 0, "R5 code before enable rise");
        close_frame();
        check(dac_code, 8'hA5, "R2 code");
        check(gnd_out, 0, "R4 normal");
        check(upd_cnt, 1, "R11 strobe count");
    endtask

    task automatic test_mode_only();
        shift_bits(16'h083C, 12);
        check(gnd_out, 0, "R5 mode before enable rise");
        close_frame();
        check(gnd_out, 1, "R4 grounded");
        check(dac_code, 8'hA5, "R3 code held");
        check(upd_cnt, 1, "R3 no strobe");
    endtask

    task automatic test_short_frames();
        shift_bits(16'h0000, 2);
        close_frame();
        check(gnd_out, 1, "R6 two edges dropped");
        shift_bits(16'h0000, 3);
        close_frame();
        check(gnd_out, 0, "R6 three edges decoded");
    endtask

    task automatic test_long_frame();
        shift_bits(16'h3C5A, 14);
        close_frame();
        check(dac_code, 8'h5A, "R7 code");
        check(gnd_out, 1, "R7 mode");
        check(upd_cnt, 2, "R7 strobe");
    endtask

    task automatic test_padded_frame();
        shift_bits(16'h043C, 11);
        close_frame();
        check(dac_code, 8'h3C, "R8 code");
        check(gnd_out, 0, "R8 mode");
        check(upd_cnt, 3, "R8 strobe");
    endtask

    task automatic test_pin_control();
        mode_sel = 1'b0;
        mode_ovr = 1'b1;
        #1 check(gnd_out, 0, "R9 pin normal");
        shift_bits(16'h0C81, 12);
        close_frame();
        check(gnd_out, 0, "R9 bit 11 ignored");
        check(dac_code, 8'h81, "R10 load with pin control");
        check(upd_cnt, 4, "R10 strobe");
        #7 mode_ovr = 1'b0;
        #1 check(gnd_out, 1, "R9 async force");
        shift_bits(16'h0000, 12);
        close_frame();
        check(gnd_out, 1, "R9 force held");
        mode_ovr = 1'b1;
        #1 check(gnd_out, 0, "R9 release");
        mode_sel = 1'b1;
        #1 check(gnd_out, 0, "R4 serial mode back");
    endtask

    initial begin
        #200000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #95 rst_n = 1'b1;
        #100;
        test_reset();
        test_full_load();
        test_mode_only();
        test_short_frames();
        test_long_frame();
        test_padded_frame();
        test_pin_control();
        check(wide_cnt, 0, "R11 strobe width");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule